// File: doc/BRIEF.md
# Store-Word Exception and Byte-Reverse Unit

This unit executes a register-plus-register store-word operation. It decodes the instruction word and adds the two source register values to form the effective address. It then tests the address against three exception conditions in a fixed priority order. If no condition applies, it issues one 32-bit write on the memory port. If one does apply, it raises a one-cycle exception strobe and records the cause in the exception-status fields. It also saves or clears the mode bits, depending on the cause.

An address-translation stub outside the block supplies a translation-miss flag, a protection-fault flag and a zone-type flag. Translation and protection faults count only while the virtual-mode bit is set. An optional reverse flag in the instruction stores the word with its four bytes in the opposite order. The parameter `REORDER_EN` decides whether that flag is legal. The parameter `AREA_OPT` selects a result latency of one or two cycles.

Top module: `stw_xcpt_unit`

## Requirements
- R1: An instruction is accepted only when `op_valid` is high, bits [31:26] equal 6'b110110 and bits [9:0] are zero. The fields are: source-data register number in [25:21], first address register number in [20:16], second address register number in [15:11], and reverse flag in bit [10]. Any other word produces no write and no strobe, and leaves every status output unchanged.
- R2: With no exception, the unit pulses `mem_we` for one cycle. `mem_addr` carries `rs_a + rs_b` (modulo 2^32), `mem_wdata` carries `rs_d`, and `mem_be` is 4'hF.
- R3: When the reverse flag is 1 and accepted, `mem_wdata` is `{rs_d[7:0], rs_d[15:8], rs_d[23:16], rs_d[31:24]}`.
- R4: With `REORDER_EN` = 0, an instruction whose reverse flag is 1 is ignored, as in R1.
- R5: Priority is translation miss first, then protection fault, then misalignment, and only the first that applies is taken. The first two are considered only while `mode_vm` is 1. With `mode_vm` = 0, `xlat_miss` and `prot_fault` have no effect.
- R6: `xcpt_code` becomes 5'b10010 for a translation miss, 5'b10000 for a protection fault and 5'b00001 for misalignment. It holds its value until the next exception.
- R7: On a translation miss or protection fault, `xs_store` becomes 1, `saved_um` takes `mode_um`, `saved_vm` takes `mode_vm`, and `vm_out` and `um_out` become 0. `saved_vm` and `saved_um` change only on these exceptions. On any other accepted instruction, `vm_out`/`um_out` take `mode_vm`/`mode_um`.
- R8: On a protection fault, `xs_dzone` becomes `prot_noaccess & mode_um`. A no-access zone is recognised only in user mode. Otherwise `xs_dzone` holds its value.
- R9: An address is misaligned when its two low bits are not both zero. A misalignment sets `xs_word` = 1 and `xs_store` = 1, and sets `xs_reg` to the source-data register number. A write never carries a misaligned address.
- R10: While an exception is raised, `mem_we` stays low. `xcpt_strobe` is high for exactly one cycle per excepting instruction.
- R11: Results appear 1 clock edge after acceptance when `AREA_OPT` = 0, and 2 edges after when `AREA_OPT` = 1.
- R12: After a synchronous active-high reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Instruction word and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| rs_a | input | 32 | First address operand |
| rs_b | input | 32 | Second address operand |
| rs_d | input | 32 | Store data |
| mode_vm | input | 1 | Current virtual-mode bit |
| mode_um | input | 1 | Current user-mode bit |
| xlat_miss | input | 1 | No valid translation for the address |
| prot_fault | input | 1 | Access refused by zone protection |
| prot_noaccess | input | 1 | Refusing zone is no-access (1) or read-only (0) |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| xcpt_strobe | output | 1 | Exception raised, one cycle |
| xcpt_code | output | 5 | Exception cause code |
| xs_store | output | 1 | Exception came from a store |
| xs_word | output | 1 | Misaligned access was word sized |
| xs_dzone | output | 1 | Protection fault came from a no-access zone |
| xs_reg | output | 5 | Source-data register number of the misaligned store |
| vm_out | output | 1 | Updated virtual-mode bit |
| um_out | output | 1 | Updated user-mode bit |
| saved_vm | output | 1 | Saved virtual-mode bit |
| saved_um | output | 1 | Saved user-mode bit |

## Verification
Every result of the unit is due at the first clock edge after acceptance in the one-cycle build, and at the second edge in the two-cycle build. The bench runs both builds side by side on the same stimulus. It samples on the falling edge that follows the due rising edge: one falling edge after issue for the fast build and two for the slow one. The slow build is also checked to be idle at the first falling edge. The fast build must be idle again at the second falling edge, which shows that its strobes last one cycle. The sweep covers every combination of the five mode and fault inputs, the reverse flag and the two low address bits.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = WORD_W / BYTE_W;
  localparam int RIDX_W  = 5;
  localparam int CODE_W  = 5;
  localparam int ALIGN_W = $clog2(LANES);

  localparam logic [5:0] STW_MAJOR = 6'b110110;

  localparam logic [CODE_W-1:0] XC_NONE  = 5'b00000;
  localparam logic [CODE_W-1:0] XC_ALIGN = 5'b00001;
  localparam logic [CODE_W-1:0] XC_PROT  = 5'b10000;
  localparam logic [CODE_W-1:0] XC_MISS  = 5'b10010;

  typedef struct packed {
    logic              valid;
    logic [WORD_W-1:0] instr;
    logic [WORD_W-1:0] opa;
    logic [WORD_W-1:0] opb;
    logic [WORD_W-1:0] data;
    logic              vm;
    logic              um;
    logic              miss;
    logic              prot;
    logic              noacc;
  } stw_req_t;
endpackage

// File: rtl/stw_decode.sv
module stw_decode
  import stw_pkg::*;
#(
  parameter bit REORDER_EN = 1'b1
) (
  input  logic [WORD_W-1:0] instr,
  output logic              legal,
  output logic [RIDX_W-1:0] rd_idx,
  output logic              rev
);
  logic major_ok;
  logic tail_ok;

  always_comb begin
    major_ok = (instr[31:26] == STW_MAJOR);
    tail_ok  = (instr[9:0] == 10'd0);
    rev      = instr[10];
    rd_idx   = instr[25:21];
    legal    = major_ok && tail_ok && (REORDER_EN || !rev);
  end
endmodule

// File: rtl/stw_datapath.sv
module stw_datapath
  import stw_pkg::*;
(
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic [WORD_W-1:0] data,
  input  logic              rev,
  output logic [WORD_W-1:0] eff_addr,
  output logic [WORD_W-1:0] wdata
);
  logic [WORD_W-1:0] swapped;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign swapped[BYTE_W*i +: BYTE_W] = data[BYTE_W*(LANES-1-i) +: BYTE_W];
  end

  always_comb begin
    eff_addr = opa + opb;
    wdata    = rev ? swapped : data;
  end
endmodule

// File: rtl/stw_xcpt_eval.sv
module stw_xcpt_eval
  import stw_pkg::*;
(
  input  logic               vm,
  input  logic               um,
  input  logic               miss,
  input  logic               prot,
  input  logic               noacc,
  input  logic [ALIGN_W-1:0] addr_lo,
  output logic               take,
  output logic               vmode_hit,
  output logic               prot_hit,
  output logic               dzone,
  output logic [CODE_W-1:0]  code
);
  logic miss_hit;
  logic algn_hit;

  always_comb begin
    miss_hit  = vm && miss;
    prot_hit  = vm && prot && !miss_hit;
    algn_hit  = !miss_hit && !prot_hit && (addr_lo != '0);
    vmode_hit = miss_hit || prot_hit;
    take      = vmode_hit || algn_hit;
    dzone     = noacc && um;
    if (miss_hit)      code = XC_MISS;
    else if (prot_hit) code = XC_PROT;
    else if (algn_hit) code = XC_ALIGN;
    else               code = XC_NONE;
  end
endmodule

// File: rtl/stw_xcpt_unit.sv
module stw_xcpt_unit
  import stw_pkg::*;
#(
  parameter bit REORDER_EN = 1'b1,
  parameter bit AREA_OPT   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] rs_a,
  input  logic [WORD_W-1:0] rs_b,
  input  logic [WORD_W-1:0] rs_d,
  input  logic              mode_vm,
  input  logic              mode_um,
  input  logic              xlat_miss,
  input  logic              prot_fault,
  input  logic              prot_noaccess,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              xcpt_strobe,
  output logic [CODE_W-1:0] xcpt_code,
  output logic              xs_store,
  output logic              xs_word,
  output logic              xs_dzone,
  output logic [RIDX_W-1:0] xs_reg,
  output logic              vm_out,
  output logic              um_out,
  output logic              saved_vm,
  output logic              saved_um
);
  stw_req_t req;
  stw_req_t st;

  always_comb begin
    req.valid = op_valid;
    req.instr = instr;
    req.opa   = rs_a;
    req.opb   = rs_b;
    req.data  = rs_d;
    req.vm    = mode_vm;
    req.um    = mode_um;
    req.miss  = xlat_miss;
    req.prot  = prot_fault;
    req.noacc = prot_noaccess;
  end

  // Optional operand stage trades a cycle of latency for a shorter path.
  if (AREA_OPT) begin : g_stage
    stw_req_t st_q;
    always_ff @(posedge clk) begin
      if (rst) st_q <= '0;
      else     st_q <= req;
    end
    assign st = st_q;
  end else begin : g_direct
    assign st = req;
  end

  logic              legal;
  logic [RIDX_W-1:0] rd_idx;
  logic              rev;
  logic [WORD_W-1:0] eff_addr;
  logic [WORD_W-1:0] wdata;
  logic              take;
  logic              vmode_hit;
  logic              prot_hit;
  logic              dzone;
  logic [CODE_W-1:0] code;

  stw_decode #(.REORDER_EN(REORDER_EN)) u_dec (
    .instr (st.instr),
    .legal (legal),
    .rd_idx(rd_idx),
    .rev   (rev)
  );

  stw_datapath u_dp (
    .opa     (st.opa),
    .opb     (st.opb),
    .data    (st.data),
    .rev     (rev),
    .eff_addr(eff_addr),
    .wdata   (wdata)
  );

  stw_xcpt_eval u_xe (
    .vm       (st.vm),
    .um       (st.um),
    .miss     (st.miss),
    .prot     (st.prot),
    .noacc    (st.noacc),
    .addr_lo  (eff_addr[ALIGN_W-1:0]),
    .take     (take),
    .vmode_hit(vmode_hit),
    .prot_hit (prot_hit),
    .dzone    (dzone),
    .code     (code)
  );

  logic accept;
  assign accept = st.valid && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we      <= 1'b0;
      mem_be      <= '0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      xcpt_strobe <= 1'b0;
      xcpt_code   <= '0;
      xs_store    <= 1'b0;
      xs_word     <= 1'b0;
      xs_dzone    <= 1'b0;
      xs_reg      <= '0;
      vm_out      <= 1'b0;
      um_out      <= 1'b0;
      saved_vm    <= 1'b0;
      saved_um    <= 1'b0;
    end else begin
      mem_we      <= 1'b0;
      xcpt_strobe <= 1'b0;
      if (accept) begin
        mem_addr  <= eff_addr;
        mem_wdata <= wdata;
        mem_be    <= '1;
        vm_out    <= st.vm;
        um_out    <= st.um;
        if (!take) begin
          mem_we <= 1'b1;
        end else begin
          xcpt_strobe <= 1'b1;
          xcpt_code   <= code;
          xs_store    <= 1'b1;
          if (vmode_hit) begin
            saved_vm <= st.vm;
            saved_um <= st.um;
            vm_out   <= 1'b0;
            um_out   <= 1'b0;
            if (prot_hit) xs_dzone <= dzone;
          end else begin
            xs_word <= 1'b1;
            xs_reg  <= rd_idx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stw_xcpt_chk.sv
module stw_xcpt_chk
  import stw_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_be,
  input logic [WORD_W-1:0] mem_addr,
  input logic              xcpt_strobe,
  input logic [CODE_W-1:0] xcpt_code,
  input logic              xs_store,
  input logic              xs_word,
  input logic              vm_out,
  input logic              um_out,
  input logic              saved_vm,
  input logic              saved_um
);
  assert_no_write_on_xcpt_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && xcpt_strobe));

  assert_full_lanes_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be == {LANES{1'b1}}));

  assert_aligned_write_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ALIGN_W-1:0] == '0));

  assert_known_code_R6: assert property (@(posedge clk) disable iff (rst)
    xcpt_strobe |-> (xcpt_code == XC_MISS || xcpt_code == XC_PROT || xcpt_code == XC_ALIGN));

  assert_vmode_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    (xcpt_strobe && xcpt_code != XC_ALIGN) |-> (!vm_out && !um_out && xs_store));

  assert_align_fields_R9: assert property (@(posedge clk) disable iff (rst)
    (xcpt_strobe && xcpt_code == XC_ALIGN) |-> (xs_word && xs_store));

  assert_saved_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !xcpt_strobe |-> ($stable(saved_vm) && $stable(saved_um)));
endmodule

bind stw_xcpt_unit stw_xcpt_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_we     (mem_we),
  .mem_be     (mem_be),
  .mem_addr   (mem_addr),
  .xcpt_strobe(xcpt_strobe),
  .xcpt_code  (xcpt_code),
  .xs_store   (xs_store),
  .xs_word    (xs_word),
  .vm_out     (vm_out),
  .um_out     (um_out),
  .saved_vm   (saved_vm),
  .saved_um   (saved_um)
);

// File: tb/sim_stw_xcpt_unit.sv
`timescale 1ns/1ps
module sim_stw_xcpt_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        op_valid = 1'b0;
  logic [31:0] instr = '0, rs_a = '0, rs_b = '0, rs_d = '0;
  logic        mode_vm = 0, mode_um = 0, xlat_miss = 0, prot_fault = 0, prot_noaccess = 0;

  logic        we0, str0, s0, w0, dz0, vm0, um0, svm0, sum0;
  logic [3:0]  be0;
  logic [31:0] ad0, wd0;
  logic [4:0]  cd0, rx0;
  logic        we1, str1, s1, w1, dz1, vm1, um1, svm1, sum1;
  logic [3:0]  be1;
  logic [31:0] ad1, wd1;
  logic [4:0]  cd1, rx1;

  stw_xcpt_unit #(.REORDER_EN(1'b1), .AREA_OPT(1'b0)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr), .rs_a(rs_a), .rs_b(rs_b),
    .rs_d(rs_d), .mode_vm(mode_vm), .mode_um(mode_um), .xlat_miss(xlat_miss),
    .prot_fault(prot_fault), .prot_noaccess(prot_noaccess), .mem_we(we0), .mem_be(be0),
    .mem_addr(ad0), .mem_wdata(wd0), .xcpt_strobe(str0), .xcpt_code(cd0), .xs_store(s0),
    .xs_word(w0), .xs_dzone(dz0), .xs_reg(rx0), .vm_out(vm0), .um_out(um0),
    .saved_vm(svm0), .saved_um(sum0));

  stw_xcpt_unit #(.REORDER_EN(1'b0), .AREA_OPT(1'b1)) u1 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr), .rs_a(rs_a), .rs_b(rs_b),
    .rs_d(rs_d), .mode_vm(mode_vm), .mode_um(mode_um), .xlat_miss(xlat_miss),
    .prot_fault(prot_fault), .prot_noaccess(prot_noaccess), .mem_we(we1), .mem_be(be1),
    .mem_addr(ad1), .mem_wdata(wd1), .xcpt_strobe(str1), .xcpt_code(cd1), .xs_store(s1),
    .xs_word(w1), .xs_dzone(dz1), .xs_reg(rx1), .vm_out(vm1), .um_out(um1),
    .saved_vm(svm1), .saved_um(sum1));

  int n_chk  = 0;
  int n_fail = 0;

  // Bench model state, index 0 = reorder on / fast, 1 = reorder off / slow.
  logic        e_we[2], e_str[2], e_s[2], e_w[2], e_dz[2], e_vm[2], e_um[2], e_svm[2], e_sum[2];
  logic [31:0] e_ad[2], e_wd[2];
  logic [4:0]  e_cd[2], e_rx[2];
  logic        last_rev;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] rd,
                                     input logic rev, input logic [9:0] tail);
    return {maj, rd, 5'd3, 5'd4, rev, tail};
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 2; k++) begin
      e_we[k] = 0; e_str[k] = 0; e_s[k] = 0; e_w[k] = 0; e_dz[k] = 0; e_vm[k] = 0;
      e_um[k] = 0; e_svm[k] = 0; e_sum[k] = 0; e_ad[k] = 0; e_wd[k] = 0; e_cd[k] = 0; e_rx[k] = 0;
    end
  endtask

  task automatic model_step();
    logic [31:0] ea, sw;
    logic acc, mh, ph, ah;
    ea = rs_a + rs_b;
    sw = {rs_d[7:0], rs_d[15:8], rs_d[23:16], rs_d[31:24]};
    last_rev = instr[10];
    for (int k = 0; k < 2; k++) begin
      acc = op_valid && instr[31:26] == 6'b110110 && instr[9:0] == 0 && (k == 0 || !instr[10]);
      e_we[k] = 0; e_str[k] = 0;
      if (acc) begin
        mh = mode_vm && xlat_miss;
        ph = mode_vm && prot_fault && !mh;
        ah = !mh && !ph && (ea[1:0] != 0);
        e_ad[k] = ea; e_wd[k] = instr[10] ? sw : rs_d;
        e_vm[k] = mode_vm; e_um[k] = mode_um;
        if (!(mh || ph || ah)) e_we[k] = 1;
        else begin
          e_str[k] = 1; e_s[k] = 1;
          e_cd[k] = mh ? 5'b10010 : (ph ? 5'b10000 : 5'b00001);
          if (mh || ph) begin
            e_svm[k] = mode_vm; e_sum[k] = mode_um; e_vm[k] = 0; e_um[k] = 0;
            if (ph) e_dz[k] = prot_noaccess && mode_um;
          end else begin
            e_w[k] = 1; e_rx[k] = instr[25:21];
          end
        end
      end
    end
  endtask

  task automatic check_out(input int k, input string pre, input logic we, input logic [31:0] ad,
                           input logic [31:0] wd, input logic [3:0] be, input logic str,
                           input logic [4:0] cd, input logic s, input logic w, input logic dz,
                           input logic [4:0] rx, input logic vm, input logic um,
                           input logic svm, input logic sum);
    chk(we == e_we[k], {pre, " R2 R10 write strobe"}, 32'(we), 32'(e_we[k]));
    if (e_we[k]) begin
      chk(ad == e_ad[k], {pre, " R2 address"}, ad, e_ad[k]);
      chk(wd == e_wd[k], {pre, " R3 data lane order"}, wd, e_wd[k]);
      chk(be == 4'hF, {pre, " R2 byte enables"}, 32'(be), 32'hF);
    end
    chk(str == e_str[k], {pre, " R10 exception strobe"}, 32'(str), 32'(e_str[k]));
    chk(cd == e_cd[k], {pre, " R5 R6 cause code"}, 32'(cd), 32'(e_cd[k]));
    chk({vm, um, svm, sum} == {e_vm[k], e_um[k], e_svm[k], e_sum[k]}, {pre, " R7 mode bits"},
        32'({vm, um, svm, sum}), 32'({e_vm[k], e_um[k], e_svm[k], e_sum[k]}));
    chk(dz == e_dz[k], {pre, " R8 zone flag"}, 32'(dz), 32'(e_dz[k]));
    chk({s, w, rx} == {e_s[k], e_w[k], e_rx[k]}, {pre, " R9 store/word/reg"},
        32'({s, w, rx}), 32'({e_s[k], e_w[k], e_rx[k]}));
  endtask

  // Issue on a falling edge; fast build due one falling edge later, slow build two.
  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] d, input logic [4:0] fl);
    instr = ins; rs_a = a; rs_b = b; rs_d = d;
    {prot_noaccess, prot_fault, xlat_miss, mode_um, mode_vm} = fl;
    op_valid = 1'b1;
    model_step();
    @(negedge clk);
    op_valid = 1'b0;
    check_out(0, "u0 R11", we0, ad0, wd0, be0, str0, cd0, s0, w0, dz0, rx0, vm0, um0, svm0, sum0);
    chk(!we1 && !str1, "u1 R11 not yet due", 32'({we1, str1}), 32'h0);
    @(negedge clk);
    check_out(1, last_rev ? "u1 R4 reverse ignored" : "u1 R11 two-cycle",
              we1, ad1, wd1, be1, str1, cd1, s1, w1, dz1, rx1, vm1, um1, svm1, sum1);
    chk(!we0 && !str0, "u0 R10 single-cycle pulse", 32'({we0, str0}), 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk({we0, str0, s0, w0, dz0, vm0, um0, svm0, sum0, be0, cd0, rx0} == '0, "R12 reset u0 flags", 0, 0);
    chk(ad0 == 0 && wd0 == 0, "R12 reset u0 bus", ad0 | wd0, 0);
    chk({we1, str1, s1, w1, dz1, vm1, um1, svm1, sum1} == '0, "R12 reset u1 flags", 0, 0);

    // Full sweep over modes, faults, reverse flag and low address bits (R3 R5 R6 R7 R8 R9).
    for (int c = 0; c < 256; c++) begin
      logic [31:0] d;
      d = 32'hA1B2C3D4 + 32'(c) * 32'h01030507;
      issue(mk(6'b110110, 5'(c * 7), c[5], 10'd0), 32'h0000_4000 + 32'(c) * 16,
            32'h0010_0000 | 32'(c[7:6]), d, c[4:0]);
    end

    // R2 address wrap-around.
    issue(mk(6'b110110, 5'd9, 1'b0, 10'd0), 32'hFFFF_FFFC, 32'h8, 32'h0BAD_F00D, 5'b00000);
    // R1 wrong major opcode with faults raised: ignored.
    issue(mk(6'b110100, 5'd5, 1'b0, 10'd0), 32'h1, 32'h0, 32'h12345678, 5'b00111);
    // R1 nonzero tail bits: ignored.
    issue(mk(6'b110110, 5'd6, 1'b0, 10'h001), 32'h2, 32'h0, 32'h87654321, 5'b00011);
    // R5 misaligned and miss together with VM=0: misaligned wins.
    issue(mk(6'b110110, 5'd17, 1'b0, 10'd0), 32'h3, 32'h0, 32'h55AA55AA, 5'b00110);
    // R3 reversal with aligned write and VM=0 bypass.
    issue(mk(6'b110110, 5'd2, 1'b1, 10'd0), 32'h100, 32'h20, 32'h01020304, 5'b01100);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule